// File: doc/BRIEF.md
# USB Controller Interrupt Register Wrapper

This block sits between a USB on-the-go controller core and a host processor. It collects the core's per-endpoint transmit and receive event lines, and its nine general USB event lines, into two 32-bit event-source registers. Software reaches them through a small 32-bit register bus. Each source register has a write-one-to-set alias and a write-one-to-clear alias. It also has an enable mask with its own set and clear aliases, and a read-only view of the source ANDed with the mask.

One level interrupt goes to the processor. After it has fired, it stays low until software writes the end-of-interrupt register. This lets the handler clear sources one by one without extra edges reaching the interrupt controller. The wrapper also provides a constant revision word, a control register that sends a one-cycle soft-reset pulse to the core, and a status register that shows the synchronized VBUS-drive level from the transceiver.

Top module: `usbirq_glue`

## Requirements
- R1: After reset, `cpu_irq` and `core_soft_rst` are 0, every source and mask bit is 0, and offset 0x00 reads the nonzero constant `REVISION` (default 0x0002_0107).
- R2: Register offsets:
  - Endpoint bank: source 0x20, source-set 0x24, source-clear 0x28, mask 0x2C, mask-set 0x30, mask-clear 0x34, masked view 0x38.
  - Core bank: the same seven registers at 0x40 to 0x58.
  - Other registers: revision 0x00, control 0x04, status 0x08, end-of-interrupt 0x60.
  - The set and clear aliases read back the source or the mask. Unmapped offsets read 0.
- R3: Source and mask registers change under software control only through their aliases. A one written to a set alias sets that bit, a one written to a clear alias clears it, and zero bits leave bits unchanged. A write to the source (0x20/0x40) or mask (0x2C/0x4C) offset itself is ignored.
- R4: Endpoint word layout: bits 15:0 are `ep_tx_evt[15:0]`, bits 31:17 are `ep_rx_evt[15:1]`, and bit 16 always reads 0. This holds in the source, the mask and the masked view, whatever is written or pulsed, including `ep_rx_evt[0]`.
- R5: Core word layout: bits 24:16 hold `core_evt[8:0]`, and the VBUS-drive event `core_evt[8]` lands on bit 24. Every other bit always reads 0.
- R6: The masked view of each bank reads source AND mask.
- R7: A high event input sets its source bit at the clock edge, readable after that edge. An event in the same cycle as a software clear of that bit leaves the bit set.
- R8: When the interrupt is armed, `cpu_irq` rises one cycle after any masked bit of either bank becomes nonzero. A bit forced through a set alias raises it exactly as a hardware event does.
- R9: Once `cpu_irq` has been high, it falls when no masked bit remains. It stays low until a write to 0x60, whatever the data, even if new masked bits appear. The end-of-interrupt write raises `cpu_irq` after the same edge if any masked bit is then nonzero.
- R10: Writing 1 to bit 0 of control (0x04) gives a one-cycle `core_soft_rst` pulse after that edge. Writing 0 gives none, and control reads 0.
- R11: Status (0x08) bit 0 shows `vbus_drive` after a two-flop synchronizer, so the bit follows two cycles after the input. Writes to revision, status and the masked views are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, qualifies `reg_sel` |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ep_tx_evt | input | 16 | Transmit endpoint event lines 0..15 |
| ep_rx_evt | input | 16 | Receive endpoint event lines (bit 0 unused) |
| core_evt | input | 9 | General USB event lines, bit 8 = VBUS-drive |
| vbus_drive | input | 1 | Asynchronous VBUS-drive level from the transceiver |
| cpu_irq | output | 1 | Level interrupt to the processor |
| core_soft_rst | output | 1 | One-cycle soft-reset pulse to the core |

## Verification
The assertions assume that event lines are synchronous to `clk` and that a single bus access carries one address per cycle. Under that assumption the set and clear aliases of one bank are never written in the same cycle. They also assume `vbus_drive` may change at any time, so only its synchronized copy is checked. The bench changes every input at the falling clock edge, issues one register access per cycle, and holds event pulses for exactly one cycle. It deliberately lines up a hardware event with a software clear of the same bit so that the priority rule is exercised.

// File: rtl/usbirq_pkg.sv
// Package: register offsets and bank layouts shared by the interrupt wrapper.
// Assumes byte offsets on an 8-bit address and 32-bit registers.
package usbirq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_REV       = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL      = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EP_BASE   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CORE_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_EOI       = 8'h60;

    // Offsets within one seven-register bank.
    localparam logic [ADDR_W-1:0] BK_SRC    = 8'h00;
    localparam logic [ADDR_W-1:0] BK_SET    = 8'h04;
    localparam logic [ADDR_W-1:0] BK_CLR    = 8'h08;
    localparam logic [ADDR_W-1:0] BK_MASK   = 8'h0C;
    localparam logic [ADDR_W-1:0] BK_MSET   = 8'h10;
    localparam logic [ADDR_W-1:0] BK_MCLR   = 8'h14;
    localparam logic [ADDR_W-1:0] BK_MASKED = 8'h18;

    localparam int NUM_EP    = 16;
    localparam int RX_LSB    = 16;
    localparam int CORE_W    = 9;
    localparam int CORE_LSB  = 16;

    // Implemented bits of each bank.
    localparam logic [DATA_W-1:0] EP_VALID   = 32'hFFFE_FFFF;
    localparam logic [DATA_W-1:0] CORE_VALID = ((32'h1 << CORE_W) - 32'h1) << CORE_LSB;

    // Decoded write strobes for one bank.
    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
    } bank_wr_t;
endpackage

// File: rtl/usbirq_sync.sv
// Module: multi-flop level synchronizer.
// Assumes STAGES >= 2 and a quasi-static input level.
module usbirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/usbirq_bank.sv
// Module: one event-source register plus enable mask with set/clear aliases.
// Assumes at most one of the four write strobes is high per cycle and that
// hw_evt is synchronous to clk. Bits outside VALID are held at zero.
module usbirq_bank
    import usbirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hw_evt,
    input  bank_wr_t          wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] masked
);
    logic [DATA_W-1:0] src_n, mask_n;

    // Next source: software set, then clear, then hardware events win.
    always_comb begin
        src_n = src;
        if (wr.src_set) src_n = src_n | wdata;
        if (wr.src_clr) src_n = src_n & ~wdata;
        src_n = (src_n | hw_evt) & VALID;
    end

    // Next mask: only the mask aliases touch it.
    always_comb begin
        mask_n = mask;
        if (wr.msk_set) mask_n = mask_n | wdata;
        if (wr.msk_clr) mask_n = mask_n & ~wdata;
        mask_n = mask_n & VALID;
    end

    // State registers of the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            mask <= '0;
        end else begin
            src  <= src_n;
            mask <= mask_n;
        end
    end

    assign masked = src & mask;

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((src & ~VALID) == '0) && ((mask & ~VALID) == '0));

    a_r7_hw_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_evt & VALID) != '0) |=>
        ((src & $past(hw_evt & VALID)) == $past(hw_evt & VALID)));

    a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        wr.src_clr |=> ((src & $past(wdata & ~hw_evt)) == '0));

    a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr.msk_clr |=> ((mask & $past(wdata)) == '0));

    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr.msk_set || wr.msk_clr) |=> $stable(mask));
endmodule

// File: rtl/usbirq_gate.sv
// Module: level interrupt with end-of-interrupt re-arm.
// Assumes pending is a registered OR of masked sources. After the output has
// fired, it cannot rise again until eoi_wr is seen.
module usbirq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi_wr,
    output logic irq
);
    logic armed;
    logic irq_n;

    // Output stays high while pending, or rises when armed or just re-armed.
    always_comb irq_n = pending & (irq | armed | eoi_wr);

    // Track the output and the arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            armed <= 1'b1;
        end else begin
            irq <= irq_n;
            if (irq_n)       armed <= 1'b0;
            else if (eoi_wr) armed <= 1'b1;
        end
    end

    a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !armed && !eoi_wr) |=> !irq);

    a_r9_eoi_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && pending) |=> irq);

    a_r8_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(pending));
endmodule

// File: rtl/usbirq_glue.sv
// Module: top of the USB controller interrupt wrapper. Decodes a simple
// 32-bit register bus, maps core event lines into an endpoint bank and a
// core bank, drives one gated level interrupt, a soft-reset pulse and a
// status view of the synchronized VBUS-drive level.
// Assumes one access per cycle; read data is combinational from reg_addr.
module usbirq_glue
    import usbirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] REVISION    = 32'h0002_0107,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_EP-1:0] ep_tx_evt,
    input  logic [NUM_EP-1:0] ep_rx_evt,
    input  logic [CORE_W-1:0] core_evt,
    input  logic              vbus_drive,
    output logic              cpu_irq,
    output logic              core_soft_rst
);
    localparam int NUM_BANKS = 2;
    localparam logic [ADDR_W-1:0] BANK_BASE [NUM_BANKS] = '{OFS_EP_BASE, OFS_CORE_BASE};
    localparam logic [DATA_W-1:0] BANK_VALID [NUM_BANKS] = '{EP_VALID, CORE_VALID};

    logic              wr_en;
    logic [DATA_W-1:0] hw_evt [NUM_BANKS];
    bank_wr_t          bank_wr [NUM_BANKS];
    logic [DATA_W-1:0] src    [NUM_BANKS];
    logic [DATA_W-1:0] mask   [NUM_BANKS];
    logic [DATA_W-1:0] masked [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_pend;
    logic              vbus_sync;
    logic              eoi_wr;
    logic              ctrl_rst_wr;

    assign wr_en = reg_sel & reg_wr;

    // Place the event lines at their bit positions in each bank word.
    always_comb begin
        hw_evt[0] = '0;
        hw_evt[0][NUM_EP-1:0] = ep_tx_evt;
        hw_evt[0][RX_LSB+NUM_EP-1:RX_LSB+1] = ep_rx_evt[NUM_EP-1:1];
        hw_evt[1] = '0;
        hw_evt[1][CORE_LSB+CORE_W-1:CORE_LSB] = core_evt;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Decode the four write aliases of this bank.
        always_comb begin
            bank_wr[b].src_set = wr_en && (reg_addr == BANK_BASE[b] + BK_SET);
            bank_wr[b].src_clr = wr_en && (reg_addr == BANK_BASE[b] + BK_CLR);
            bank_wr[b].msk_set = wr_en && (reg_addr == BANK_BASE[b] + BK_MSET);
            bank_wr[b].msk_clr = wr_en && (reg_addr == BANK_BASE[b] + BK_MCLR);
        end

        usbirq_bank #(.VALID(BANK_VALID[b])) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_evt (hw_evt[b]),
            .wr     (bank_wr[b]),
            .wdata  (reg_wdata),
            .src    (src[b]),
            .mask   (mask[b]),
            .masked (masked[b])
        );

        assign bank_pend[b] = |masked[b];
    end

    assign eoi_wr      = wr_en && (reg_addr == OFS_EOI);
    assign ctrl_rst_wr = wr_en && (reg_addr == OFS_CTRL) && reg_wdata[0];

    usbirq_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|bank_pend),
        .eoi_wr  (eoi_wr),
        .irq     (cpu_irq)
    );

    usbirq_sync #(.STAGES(SYNC_STAGES)) u_vbus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vbus_drive),
        .q     (vbus_sync)
    );

    // One-cycle soft-reset pulse after a control write of bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) core_soft_rst <= 1'b0;
        else        core_soft_rst <= ctrl_rst_wr;
    end

    // Read multiplexer over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_REV:    reg_rdata = REVISION;
            OFS_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, vbus_sync};
            default: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (reg_addr == BANK_BASE[b] + BK_SRC ||
                        reg_addr == BANK_BASE[b] + BK_SET ||
                        reg_addr == BANK_BASE[b] + BK_CLR)
                        reg_rdata = src[b];
                    if (reg_addr == BANK_BASE[b] + BK_MASK ||
                        reg_addr == BANK_BASE[b] + BK_MSET ||
                        reg_addr == BANK_BASE[b] + BK_MCLR)
                        reg_rdata = mask[b];
                    if (reg_addr == BANK_BASE[b] + BK_MASKED)
                        reg_rdata = masked[b];
                end
            end
        endcase
    end

    a_r10_soft_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == OFS_CTRL && reg_wdata[0]) |=> core_soft_rst);

    a_r10_no_spurious_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == OFS_CTRL && reg_wdata[0]) |=> !core_soft_rst);

    a_r1_rev_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_REV) |-> (reg_rdata != '0));
endmodule

// File: tb/usbirq_glue_test.sv
// Bench for usbirq_glue: a vector table walked by one loop, then directed
// tests for reset, interrupt gating, event/clear collision and sync delay.
module usbirq_glue_test;
    localparam logic [31:0] REV = 32'h0002_0107;
    localparam int NVEC = 13;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] ep_tx_evt = '0;
    logic [15:0] ep_rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        vbus_drive = 1'b0;
    logic        cpu_irq;
    logic        core_soft_rst;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] rd;

    usbirq_glue uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ep_tx_evt(ep_tx_evt), .ep_rx_evt(ep_rx_evt), .core_evt(core_evt),
        .vbus_drive(vbus_drive), .cpu_irq(cpu_irq), .core_soft_rst(core_soft_rst)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog expired: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Vector: {write addr, write data, read addr, expected, requirement number}.
    localparam logic [87:0] VEC [NVEC] = '{
        {8'h30, 32'hFFFF_FFFF, 8'h2C, 32'hFFFE_FFFF, 8'd4},  // R4 bit 16 never sets
        {8'h34, 32'h0000_00FF, 8'h2C, 32'hFFFE_FF00, 8'd3},  // R3 mask clear alias
        {8'h24, 32'h0001_0003, 8'h20, 32'h0000_0003, 8'd4},  // R4 reserved bit
        {8'h20, 32'h0000_00F0, 8'h20, 32'h0000_0003, 8'd3},  // R3 base write ignored
        {8'h38, 32'hFFFF_FFFF, 8'h38, 32'h0000_0000, 8'd11}, // R11 masked view read-only
        {8'h24, 32'h8000_0100, 8'h38, 32'h8000_0100, 8'd6},  // R6 masked = src & mask
        {8'h28, 32'h0000_0001, 8'h24, 32'h8000_0102, 8'd3},  // R3 clear, R2 alias reads src
        {8'h50, 32'hFFFF_FFFF, 8'h4C, 32'h01FF_0000, 8'd5},  // R5 core field
        {8'h44, 32'h0100_0000, 8'h58, 32'h0100_0000, 8'd5},  // R5 VBUS-drive bit 24
        {8'h48, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000, 8'd3},  // R3 clear all core
        {8'h00, 32'h0000_0000, 8'h00, REV,           8'd11}, // R11 revision read-only
        {8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_0000, 8'd11}, // R11 status read-only
        {8'h28, 32'hFFFF_FFFF, 8'h20, 32'h0000_0000, 8'd3}   // R3 clear all endpoint
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h, expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        // Reset
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", {31'b0, cpu_irq}, 32'h0);
        chk("R1 soft reset after reset", {31'b0, core_soft_rst}, 32'h0);
        rdreg(8'h00, rd); chk("R1 revision", rd, REV);
        rdreg(8'h20, rd); chk("R1 ep source", rd, 32'h0);
        rdreg(8'h4C, rd); chk("R1 core mask", rd, 32'h0);
        rdreg(8'h70, rd); chk("R2 unmapped reads zero", rd, 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][87:80], VEC[i][79:48]);
            rdreg(VEC[i][47:40], rd);
            chk($sformatf("R%0d table row %0d", VEC[i][7:0], i), rd, VEC[i][39:8]);
        end
        // All sources clear now; let irq fall, then re-arm.
        wait_cyc(2);
        chk("R9 irq low with nothing pending", {31'b0, cpu_irq}, 32'h0);
        wr(8'h60, 32'h0);

        // R7 / R8: hardware event, irq one cycle later
        ep_tx_evt[9] = 1'b1;
        @(negedge clk);
        ep_tx_evt[9] = 1'b0;
        rdreg(8'h20, rd); chk("R7 hw event sets bit 9", rd, 32'h0000_0200);
        chk("R8 irq not yet", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq one cycle after event", {31'b0, cpu_irq}, 32'h1);

        // R9: clear, new event stays blocked until end-of-interrupt
        wr(8'h28, 32'h0000_0200);
        @(negedge clk);
        chk("R9 irq falls when cleared", {31'b0, cpu_irq}, 32'h0);
        ep_tx_evt[10] = 1'b1;
        @(negedge clk);
        ep_tx_evt[10] = 1'b0;
        wait_cyc(3);
        chk("R9 irq blocked before EOI", {31'b0, cpu_irq}, 32'h0);
        wr(8'h60, 32'hDEAD_BEEF);
        chk("R9 irq after EOI with pending", {31'b0, cpu_irq}, 32'h1);

        // R7 collision: event and clear of the same bit in one cycle
        @(negedge clk);
        ep_tx_evt[10] = 1'b1;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h0000_0400;
        @(negedge clk);
        ep_tx_evt[10] = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
        rdreg(8'h20, rd); chk("R7 event wins over clear", rd, 32'h0000_0400);
        wr(8'h28, 32'h0000_0400);
        wait_cyc(1);
        wr(8'h60, 32'h0);
        chk("R9 EOI with nothing pending keeps irq low", {31'b0, cpu_irq}, 32'h0);

        // R8: forced core event through the set alias
        wr(8'h44, 32'h0100_0000);
        chk("R8 forced event irq not yet", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        chk("R8 forced event raises irq", {31'b0, cpu_irq}, 32'h1);
        wr(8'h48, 32'h0100_0000);
        wait_cyc(1);
        wr(8'h60, 32'h0);

        // R5: core VBUS-drive event line lands on bit 24
        @(negedge clk);
        core_evt[8] = 1'b1;
        @(negedge clk);
        core_evt[8] = 1'b0;
        rdreg(8'h40, rd); chk("R5 core_evt[8] at bit 24", rd, 32'h0100_0000);
        wr(8'h48, 32'hFFFF_FFFF);

        // R4: receive lines, bit 0 ignored
        @(negedge clk);
        ep_rx_evt = 16'h8001;
        @(negedge clk);
        ep_rx_evt = '0;
        rdreg(8'h20, rd); chk("R4 rx 15 to bit 31, rx 0 ignored", rd, 32'h8000_0000);
        wr(8'h28, 32'hFFFF_FFFF);

        // R10: soft reset pulse
        wr(8'h04, 32'h0000_0001);
        chk("R10 soft reset pulse", {31'b0, core_soft_rst}, 32'h1);
        @(negedge clk);
        chk("R10 pulse one cycle", {31'b0, core_soft_rst}, 32'h0);
        wr(8'h04, 32'h0000_0000);
        chk("R10 write of 0 no pulse", {31'b0, core_soft_rst}, 32'h0);
        rdreg(8'h04, rd); chk("R10 control reads zero", rd, 32'h0);

        // R11: VBUS-drive synchronizer delay
        @(negedge clk);
        vbus_drive = 1'b1;
        @(negedge clk);
        rdreg(8'h08, rd); chk("R11 status after one edge", rd, 32'h0);
        @(negedge clk);
        rdreg(8'h08, rd); chk("R11 status after two edges", rd, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule